// File: doc/BRIEF.md
# Receive Character Buffer with Error Tracking

This block holds the characters a UART receive shifter has assembled until the CPU reads them. In buffered mode it keeps up to sixteen entries. Each entry carries the 8-bit character and three error marks: break, framing and parity. The CPU sees the oldest character together with its three marks. A status read leaves the buffer untouched, and only a data read removes the oldest entry. The block also keeps a flag that is set while any stored entry carries an error.

The block drives the indications an interrupt encoder needs:
- a data-ready flag;
- a trigger-level hit against a selectable threshold;
- an overrun flag for characters lost to a full buffer;
- an idle time-out, raised when a few characters sit below the threshold and the line has gone quiet for four character times.

A flush strobe empties the buffer at once. With buffered mode off, the block behaves as a single holding register.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset, level is 0 and data_ready, trig_hit, overrun, any_err and timeout are all 0.
- R2: Characters leave in arrival order. rd_data and head_brk/head_frm/head_par show the oldest entry. A status_rd strobe changes neither level nor the head, while a pop strobe removes exactly one entry. data_ready is 1 exactly when level is non-zero.
- R3: any_err is 1 while at least one stored entry has any of its three error marks set, and it falls to 0 in the cycle after the last such entry is popped.
- R4: trig_hit is 1 when level is at or above the threshold chosen by trig_sel: 2'b00 selects 1, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14.
- R5: A character that arrives while the buffer is full and no pop occurs is dropped, and overrun becomes 1 in the next cycle. overrun stays set until a status_rd strobe with no new overrun in the same cycle.
- R6: A flush strobe leaves level 0, data_ready 0, any_err 0 and timeout 0 in the next cycle.
- R7: A character pushed with push_brk set is stored with data 8'h00 and its break mark set. Further break pushes are dropped until a push without push_brk is accepted.
- R8: With 0 < level < threshold, timeout rises after 4*char_ticks tick16 pulses with no push and no pop. Any push or pop clears timeout and restarts the count.
- R9: With fifo_mode 0, the buffer holds one entry and the threshold is 1 whatever trig_sel selects. A second character is dropped and flags an overrun.
- R10: Any change of fifo_mode empties the buffer, as a flush would, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1: 16-entry buffer, 0: single holding register |
| trig_sel | input | 2 | Threshold select (1/4/8/14) |
| char_ticks | input | 12 | 16x sample ticks per character frame |
| tick16 | input | 1 | 16x sample tick strobe |
| push_valid | input | 1 | Character from the receive shifter |
| push_data | input | 8 | Character bits |
| push_brk | input | 1 | Break detected on this character |
| push_frm | input | 1 | Framing error on this character |
| push_par | input | 1 | Parity error on this character |
| pop | input | 1 | Data read strobe, removes the oldest entry |
| status_rd | input | 1 | Status read strobe, clears overrun |
| flush | input | 1 | Empty the buffer (self-clearing strobe) |
| rd_data | output | 8 | Oldest character, 0 when empty |
| head_brk | output | 1 | Break mark of the oldest entry |
| head_frm | output | 1 | Framing mark of the oldest entry |
| head_par | output | 1 | Parity mark of the oldest entry |
| level | output | 5 | Number of stored entries |
| data_ready | output | 1 | At least one entry is stored |
| trig_hit | output | 1 | Level reached the threshold |
| timeout | output | 1 | Idle time-out below the threshold |
| overrun | output | 1 | A character was dropped on a full buffer |
| any_err | output | 1 | Some stored entry carries an error mark |

## Verification
A wrong pointer shows as a wrong character or wrong marks on the head outputs at the very next read. A wrong level count shows as data_ready or trig_hit at the wrong threshold, or as a missing overrun, within one cycle of the push that crosses the boundary. A bad error counter leaves any_err set, or clears it, one cycle after the pop that removes the last marked entry. A wrong idle count moves the time-out edge away from its exact tick, and the bench samples the cycle before and the cycle of that edge.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;

  localparam int TRIG_SEL0 = 1;
  localparam int TRIG_SEL1 = 4;
  localparam int TRIG_SEL2 = 8;
  localparam int TRIG_SEL3 = 14;

  function automatic int trig_count(input logic [1:0] sel);
    case (sel)
      2'b00:   return TRIG_SEL0;
      2'b01:   return TRIG_SEL1;
      2'b10:   return TRIG_SEL2;
      default: return TRIG_SEL3;
    endcase
  endfunction

  function automatic logic has_err(input rx_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_one,
  input  logic             wr_req,
  input  rx_entry_t        wr_entry,
  input  logic             rd_req,
  output rx_entry_t        head,
  output logic [LVL_W-1:0] level,
  output logic             wr_ok,
  output logic             rd_ok
);

  localparam logic [LVL_W-1:0] CAP_FULL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [LVL_W-1:0] cap;
  logic             full;

  assign cap   = cap_one ? LVL_W'(1) : CAP_FULL;
  assign full  = (level_q >= cap);
  assign rd_ok = rd_req && (level_q != '0);
  assign wr_ok = wr_req && (!full || rd_ok);
  assign head  = mem[rd_ptr_q];
  assign level = level_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (wr_ok) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level_d = level_q + 1'b1;
        2'b01:   level_d = level_q - 1'b1;
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clr) mem[wr_ptr_q] <= wr_entry;
  end

endmodule

// File: rtl/rxb_err_track.sv
module rxb_err_track #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic add_err,
  input  logic sub_err,
  output logic any_err
);

  logic [LVL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      case ({add_err, sub_err})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign any_err = (cnt_q != '0);

endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
  parameter int TICK_W = 12,
  localparam int CNT_W = TICK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              restart,
  input  logic              armed,
  input  logic              tick,
  input  logic [TICK_W-1:0] char_ticks,
  output logic              timeout
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit_m1;
  logic             to_q, to_d;

  assign limit_m1 = {char_ticks, 2'b00} - 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    to_d  = to_q;
    if (clr || restart) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (!armed) begin
      cnt_d = '0;
    end else if (tick && !to_q) begin
      if (cnt_q == limit_m1) to_d = 1'b1;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign timeout = to_q;

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TICK_W = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic [1:0]        trig_sel,
  input  logic [TICK_W-1:0] char_ticks,
  input  logic              tick16,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  input  logic              push_brk,
  input  logic              push_frm,
  input  logic              push_par,
  input  logic              pop,
  input  logic              status_rd,
  input  logic              flush,
  output logic [7:0]        rd_data,
  output logic              head_brk,
  output logic              head_frm,
  output logic              head_par,
  output logic [LVL_W-1:0]  level,
  output logic              data_ready,
  output logic              trig_hit,
  output logic              timeout,
  output logic              overrun,
  output logic              any_err
);

  rx_entry_t        wr_entry;
  rx_entry_t        head;
  logic             push_eff;
  logic             wr_ok, rd_ok;
  logic             clr;
  logic [LVL_W-1:0] trig_val;
  logic             armed;

  logic mode_q;
  logic brk_hold_q, brk_hold_d;
  logic ovr_q, ovr_d;

  // mode change behaves as a flush
  assign clr = flush || (fifo_mode != mode_q);

  // consecutive break characters collapse into one entry
  assign push_eff = push_valid && !(push_brk && brk_hold_q);

  always_comb begin
    wr_entry.brk  = push_brk;
    wr_entry.frm  = push_frm;
    wr_entry.par  = push_par;
    wr_entry.data = push_brk ? 8'h00 : push_data;
  end

  rxb_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cap_one  (!fifo_mode),
    .wr_req   (push_eff),
    .wr_entry (wr_entry),
    .rd_req   (pop),
    .head     (head),
    .level    (level),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok)
  );

  rxb_err_track #(.DEPTH(DEPTH)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .add_err (wr_ok && has_err(wr_entry)),
    .sub_err (rd_ok && has_err(head)),
    .any_err (any_err)
  );

  assign trig_val = fifo_mode ? LVL_W'(trig_count(trig_sel)) : LVL_W'(1);
  assign armed    = (level != '0) && (level < trig_val);

  rxb_idle_timer #(.TICK_W(TICK_W)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .restart    (wr_ok || rd_ok),
    .armed      (armed),
    .tick       (tick16),
    .char_ticks (char_ticks),
    .timeout    (timeout)
  );

  always_comb begin
    brk_hold_d = brk_hold_q;
    if (push_eff) brk_hold_d = push_brk;
    ovr_d = ovr_q;
    if (push_eff && !wr_ok) ovr_d = 1'b1;
    else if (status_rd)     ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      brk_hold_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      mode_q     <= fifo_mode;
      brk_hold_q <= brk_hold_d;
      ovr_q      <= ovr_d;
    end
  end

  assign data_ready = (level != '0);
  assign trig_hit   = data_ready && (level >= trig_val);
  assign overrun    = ovr_q;
  assign rd_data    = data_ready ? head.data : 8'h00;
  assign head_brk   = data_ready && head.brk;
  assign head_frm   = data_ready && head.frm;
  assign head_par   = data_ready && head.par;

endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             push_valid,
  input logic             push_brk,
  input logic             pop,
  input logic             status_rd,
  input logic             flush,
  input logic [LVL_W-1:0] level,
  input logic             data_ready,
  input logic             timeout,
  input logic             overrun,
  input logic             any_err
);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R9
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> (fifo_mode || level <= LVL_W'(1)));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !any_err && !timeout));

  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_brk && !pop && !flush && fifo_mode &&
     level == LVL_W'(DEPTH)) |=> overrun);

  // R5
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !push_valid) |=> !overrun);

  // R3
  err_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> data_ready);

  // R8
  pop_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !timeout);

endmodule

bind rx_char_buffer rxb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_mode  (fifo_mode),
  .push_valid (push_valid),
  .push_brk   (push_brk),
  .pop        (pop),
  .status_rd  (status_rd),
  .flush      (flush),
  .level      (level),
  .data_ready (data_ready),
  .timeout    (timeout),
  .overrun    (overrun),
  .any_err    (any_err)
);

// File: tb/sim_rx_char_buffer.sv
module sim_rx_char_buffer;

  localparam int CLK_PERIOD = 10;

  // {brk, frm, par, data}
  localparam logic [10:0] VEC [0:7] = '{
    11'h0A5, 11'h23C, 11'h0FF, 11'h001,
    11'h17E, 11'h080, 11'h055, 11'h0C3
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fifo_mode;
  logic [1:0]  trig_sel;
  logic [11:0] char_ticks;
  logic        tick16;
  logic        push_valid;
  logic [7:0]  push_data;
  logic        push_brk, push_frm, push_par;
  logic        pop, status_rd, flush;
  logic [7:0]  rd_data;
  logic        head_brk, head_frm, head_par;
  logic [4:0]  level;
  logic        data_ready, trig_hit, timeout, overrun, any_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_char_buffer u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
    .char_ticks(char_ticks), .tick16(tick16), .push_valid(push_valid),
    .push_data(push_data), .push_brk(push_brk), .push_frm(push_frm),
    .push_par(push_par), .pop(pop), .status_rd(status_rd), .flush(flush),
    .rd_data(rd_data), .head_brk(head_brk), .head_frm(head_frm),
    .head_par(head_par), .level(level), .data_ready(data_ready),
    .trig_hit(trig_hit), .timeout(timeout), .overrun(overrun), .any_err(any_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
    push_valid = 1'b1; push_data = d; push_brk = b; push_frm = f; push_par = p;
    step();
    push_valid = 1'b0; push_brk = 1'b0; push_frm = 1'b0; push_par = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; step(); pop = 1'b0;
  endtask

  task automatic do_status();
    status_rd = 1'b1; step(); status_rd = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1; step(); flush = 1'b0;
  endtask

  function automatic int tval(input int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rem;
    rst_n = 1'b0; fifo_mode = 1'b1; trig_sel = 2'b00; char_ticks = 12'd3;
    tick16 = 1'b0; push_valid = 1'b0; push_data = '0; push_brk = 1'b0;
    push_frm = 1'b0; push_par = 1'b0; pop = 1'b0; status_rd = 1'b0; flush = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 trig_hit", trig_hit, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 any_err", any_err, 0);
    chk("R1 timeout", timeout, 0);

    // R2 R3 table walk
    for (int i = 0; i < 8; i++) push(VEC[i][7:0], VEC[i][10], VEC[i][9], VEC[i][8]);
    chk("R2 level after fill", level, 8);
    chk("R3 any_err set", any_err, 1);
    for (int i = 0; i < 8; i++) begin
      do_status();
      chk("R2 status keeps level", level, 32'(8 - i));
      chk("R2 head data", rd_data, VEC[i][7:0]);
      chk("R2 head marks", {head_brk, head_frm, head_par}, VEC[i][10:8]);
      do_pop();
      rem = 0;
      for (int j = i + 1; j < 8; j++) if (VEC[j][10:8] != 3'b000) rem++;
      chk("R3 any_err after pop", any_err, (rem != 0));
      chk("R2 data_ready", data_ready, (i != 7));
    end

    // R4 threshold sweep while filling
    for (int i = 1; i <= 16; i++) begin
      push(8'(8'h10 + i - 1), 1'b0, 1'b0, 1'b0);
      for (int s = 0; s < 4; s++) begin
        trig_sel = 2'(s);
        #1;
        chk("R4 trig_hit", trig_hit, (i >= tval(s)));
      end
    end
    trig_sel = 2'b00;

    // R5 overrun on full
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R5 overrun set", overrun, 1);
    chk("R5 level held", level, 16);
    do_status();
    chk("R5 overrun cleared", overrun, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R5 kept data", rd_data, 32'(8'h10 + i));
      do_pop();
    end
    chk("R5 empty", data_ready, 0);

    // R6 flush
    push(8'h11, 1'b0, 1'b1, 1'b0);
    push(8'h22, 1'b0, 1'b0, 1'b0);
    do_flush();
    chk("R6 level", level, 0);
    chk("R6 data_ready", data_ready, 0);
    chk("R6 any_err", any_err, 0);

    // R7 break collapse
    push(8'h77, 1'b1, 1'b0, 1'b0);
    push(8'h77, 1'b1, 1'b0, 1'b0);
    chk("R7 one entry", level, 1);
    chk("R7 zero data", rd_data, 0);
    chk("R7 brk mark", head_brk, 1);
    push(8'h12, 1'b0, 1'b0, 1'b0);
    push(8'h00, 1'b1, 1'b0, 1'b0);
    chk("R7 new break after normal", level, 3);
    do_flush();

    // R8 idle time-out: limit 12 ticks
    trig_sel = 2'b01; tick16 = 1'b1;
    push(8'h31, 1'b0, 1'b0, 1'b0);
    repeat (11) step();
    chk("R8 not yet", timeout, 0);
    step();
    chk("R8 raised", timeout, 1);
    do_pop();
    chk("R8 cleared by pop", timeout, 0);
    trig_sel = 2'b00;
    push(8'h32, 1'b0, 1'b0, 1'b0);
    repeat (20) step();
    chk("R8 none at threshold", timeout, 0);
    tick16 = 1'b0;
    do_flush();

    // R9 single holding register
    fifo_mode = 1'b0;
    step();
    push(8'h41, 1'b0, 1'b0, 1'b0);
    trig_sel = 2'b11;
    #1;
    chk("R9 threshold one", trig_hit, 1);
    push(8'h42, 1'b0, 1'b0, 1'b0);
    chk("R9 overrun", overrun, 1);
    chk("R9 level", level, 1);
    chk("R9 kept first", rd_data, 8'h41);

    // R10 mode change empties
    fifo_mode = 1'b1;
    step();
    chk("R10 level", level, 0);
    chk("R10 data_ready", data_ready, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule